// File: doc/BRIEF.md
# Embedded Operation Status Flags

This block builds the status word that a host reads from a flash array while an embedded program or erase is in progress. An operation engine supplies the start pulse, busy, erase-versus-program, hold-window, suspended and timeout indications. It also supplies the most significant bit of the data being programmed and the mask of blocks chosen for erase. Each host read is given as a strobe that carries a block index, a flag that says whether the address lies in the bank under operation, and the array word for that address.

A state machine tracks the operation. Its states are `ST_IDLE`, `ST_PROG`, `ST_HOLD` (erase hold window open), `ST_ERASE`, `ST_SUSP` and `ST_FAIL`. Its transitions are:
- start: `ST_IDLE` goes to `ST_PROG` or `ST_HOLD`.
- window closed: `ST_HOLD` goes to `ST_ERASE`.
- suspend and resume: `ST_ERASE` goes to `ST_SUSP` and back.
- timeout: any running state goes to `ST_FAIL`.
- done: a busy state goes to `ST_IDLE` when busy drops.

Two toggle bits advance on read accesses, not on clock cycles. A registered output stage returns either the flag word or the array word one cycle after each strobe.

Top module: `op_status_flags`

## Requirements
- R1: After reset, `ry_by` is 1 and a read returns `array_data` unchanged.
- R2: In `ST_PROG`, bit 7 of a flag read is the complement of `prog_msb`, as latched at the start.
- R3: In `ST_HOLD` and `ST_ERASE`, bit 7 reads 0. Once busy drops, reads return array data, so an erased word of all ones shows bit 7 as 1.
- R4: Bit 6 reads 0 on the first flag read after a start. It inverts after every flag read while the operation runs, in `ST_PROG`, `ST_HOLD`, `ST_ERASE` and `ST_FAIL`.
- R5: Bit 2 inverts only after a flag read whose block is set in `erase_sel` during an erase. Reads of unselected blocks, and all reads during a program, leave it steady.
- R6: After `op_timeout`, the state is `ST_FAIL`. Bit 5 reads 1, bit 7 keeps its operation value, and bit 6 keeps toggling until busy drops.
- R7: In `ST_SUSP`, `ry_by` is 1. A read of a selected block returns bit 7 = 1 with bit 6 steady and bit 2 toggling. A read of an unselected block returns array data. After resume, bit 6 toggling continues from its held value.
- R8: Bit 3 reads 0 in `ST_HOLD` and in a program. It reads 1 in `ST_ERASE`, `ST_SUSP`, and `ST_FAIL` after an erase.
- R9: `ry_by` is 0 from the cycle after an accepted start until busy drops. From then on, reads return array data.
- R10: A read with `rd_in_bank` = 0 returns array data and advances neither toggle bit.
- R11: `rd_valid` pulses exactly one cycle after `rd_stb`. Flag words carry zeros in bits 4, 1, 0 and in every bit above 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_start | input | 1 | Start pulse for a new operation |
| op_is_erase | input | 1 | 1 = erase, 0 = program (sampled at start) |
| op_busy | input | 1 | Engine is running |
| op_suspended | input | 1 | Erase is suspended |
| op_timeout | input | 1 | Operation exceeded its time limit |
| erase_hold | input | 1 | Erase hold window still open |
| prog_msb | input | 1 | Bit 7 of the word being programmed |
| erase_sel | input | NBLK | Blocks chosen for erase |
| rd_stb | input | 1 | Host read strobe |
| rd_in_bank | input | 1 | Read address is in the bank under operation |
| rd_blk | input | BLKW | Block index of the read address |
| array_data | input | DW | Array word at the read address |
| rd_data | output | DW | Returned read word |
| rd_valid | output | 1 | `rd_data` is valid |
| ry_by | output | 1 | 1 = ready, 0 = busy |

## Verification
Assertions check the following on every cycle:
- the one-cycle strobe-to-valid latency;
- that an accepted start drives `ry_by` low;
- that both toggles clear on a start;
- that a toggle moves only after a read strobe or a start.

Only the bench scenarios can show the read-by-read sequence of the toggles. The same holds for the split between selected and unselected blocks during erase and suspend, the hold-window bit, and the timeout word keeping bit 7. All of these depend on sequences of accesses that a single-cycle property does not capture.

// File: rtl/flag_pkg.sv
package flag_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_HOLD,
        ST_ERASE,
        ST_SUSP,
        ST_FAIL
    } op_state_e;

    localparam int BIT_POLL = 7;
    localparam int BIT_TGL  = 6;
    localparam int BIT_TMO  = 5;
    localparam int BIT_WIN  = 3;
    localparam int BIT_ALT  = 2;
    localparam int NTGL     = 2;
    localparam int LANE_TGL = 0;
    localparam int LANE_ALT = 1;
endpackage

// File: rtl/flag_fsm.sv
module flag_fsm
    import flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_start,
    input  logic      op_is_erase,
    input  logic      op_busy,
    input  logic      op_suspended,
    input  logic      op_timeout,
    input  logic      erase_hold,
    input  logic      prog_msb,
    output op_state_e state,
    output logic      was_erase,
    output logic      prog_bit,
    output logic      start_ok
);
    op_state_e nxt;

    assign start_ok = op_start && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (op_start) nxt = op_is_erase ? ST_HOLD : ST_PROG;
            ST_PROG: begin
                if (!op_busy)        nxt = ST_IDLE;
                else if (op_timeout) nxt = ST_FAIL;
            end
            ST_HOLD: begin
                if (!op_busy)        nxt = ST_IDLE;
                else if (op_timeout) nxt = ST_FAIL;
                else if (!erase_hold) nxt = ST_ERASE;
            end
            ST_ERASE: begin
                if (!op_busy)          nxt = ST_IDLE;
                else if (op_timeout)   nxt = ST_FAIL;
                else if (op_suspended) nxt = ST_SUSP;
            end
            ST_SUSP:  if (!op_suspended) nxt = ST_ERASE;
            ST_FAIL:  if (!op_busy) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            was_erase <= 1'b0;
            prog_bit  <= 1'b0;
        end else begin
            state <= nxt;
            if (start_ok) begin
                was_erase <= op_is_erase;
                prog_bit  <= prog_msb;
            end
        end
    end

    AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (state == ST_PROG || state == ST_HOLD)); // R9
    AST_SUSP_ONLY_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && $past(state) != ST_SUSP) |-> $past(state) == ST_ERASE); // R7
endmodule

// File: rtl/flag_toggle.sv
module flag_toggle #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] adv,
    input  logic         rd_stb,
    output logic [N-1:0] tq
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      tq[g] <= 1'b0;
            else if (clr)    tq[g] <= 1'b0;
            else if (adv[g]) tq[g] <= ~tq[g];
        end

        AST_TGL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (tq[g] != $past(tq[g])) |-> $past(rd_stb || clr)); // R4
    end

    AST_TGL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (tq == '0)); // R4
endmodule

// File: rtl/flag_outreg.sv
module flag_outreg
    import flag_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic          flag_mode,
    input  op_state_e     state,
    input  logic          was_erase,
    input  logic          prog_bit,
    input  logic          t_tgl,
    input  logic          t_alt,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] word;
    logic          poll;
    logic          win;

    always_comb begin
        poll = 1'b0;
        win  = 1'b0;
        unique case (state)
            ST_PROG:  begin poll = ~prog_bit; win = 1'b0; end
            ST_HOLD:  begin poll = 1'b0;      win = 1'b0; end
            ST_ERASE: begin poll = 1'b0;      win = 1'b1; end
            ST_SUSP:  begin poll = 1'b1;      win = 1'b1; end
            ST_FAIL:  begin poll = was_erase ? 1'b0 : ~prog_bit; win = was_erase; end
            default:  begin poll = 1'b0;      win = 1'b0; end
        endcase
        word = '0;
        word[BIT_POLL] = poll;
        word[BIT_TGL]  = t_tgl;
        word[BIT_TMO]  = (state == ST_FAIL);
        word[BIT_WIN]  = win;
        word[BIT_ALT]  = t_alt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= flag_mode ? word : array_data;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_stb)); // R11
endmodule

// File: rtl/op_status_flags.sv
module op_status_flags
    import flag_pkg::*;
#(
    parameter int NBLK = 16,
    parameter int DW   = 16,
    localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_start,
    input  logic            op_is_erase,
    input  logic            op_busy,
    input  logic            op_suspended,
    input  logic            op_timeout,
    input  logic            erase_hold,
    input  logic            prog_msb,
    input  logic [NBLK-1:0] erase_sel,
    input  logic            rd_stb,
    input  logic            rd_in_bank,
    input  logic [BLKW-1:0] rd_blk,
    input  logic [DW-1:0]   array_data,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic            ry_by
);
    op_state_e       state;
    logic            was_erase, prog_bit, start_ok;
    logic            sel_hit, erase_ctx, flag_mode, running;
    logic [NTGL-1:0] adv, tq;

    flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .op_busy(op_busy), .op_suspended(op_suspended), .op_timeout(op_timeout),
        .erase_hold(erase_hold), .prog_msb(prog_msb), .state(state),
        .was_erase(was_erase), .prog_bit(prog_bit), .start_ok(start_ok)
    );

    assign sel_hit   = (32'(rd_blk) < NBLK) ? erase_sel[rd_blk] : 1'b0;
    assign erase_ctx = (state == ST_HOLD) || (state == ST_ERASE) ||
                       (state == ST_SUSP) || (state == ST_FAIL && was_erase);
    assign running   = (state != ST_IDLE) && (state != ST_SUSP);
    assign flag_mode = rd_in_bank && (state != ST_IDLE) &&
                       !(state == ST_SUSP && !sel_hit);
    assign ry_by     = (state == ST_IDLE) || (state == ST_SUSP);

    always_comb begin
        adv           = '0;
        adv[LANE_TGL] = rd_stb && flag_mode && running;
        adv[LANE_ALT] = rd_stb && flag_mode && erase_ctx && sel_hit;
    end

    flag_toggle #(.N(NTGL)) u_tgl (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .adv(adv),
        .rd_stb(rd_stb), .tq(tq)
    );

    flag_outreg #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .flag_mode(flag_mode),
        .state(state), .was_erase(was_erase), .prog_bit(prog_bit),
        .t_tgl(tq[LANE_TGL]), .t_alt(tq[LANE_ALT]), .array_data(array_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && state == ST_IDLE) |=> !ry_by); // R9
    AST_READY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ry_by && !$past(ry_by)) |-> $past(!op_busy || op_suspended)); // R7
    AST_OUTBANK_NO_TGL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_in_bank && !start_ok) |=> $stable(tq)); // R10
endmodule

// File: tb/sim_op_status_flags.sv
`timescale 1ns/1ps
module sim_op_status_flags;
    localparam int NBLK = 16;
    localparam int DW   = 16;
    localparam int BLKW = 4;

    logic clk = 0, rst_n = 0;
    logic op_start = 0, op_is_erase = 0, op_busy = 0, op_suspended = 0;
    logic op_timeout = 0, erase_hold = 0, prog_msb = 0;
    logic [NBLK-1:0] erase_sel = '0;
    logic rd_stb = 0, rd_in_bank = 0;
    logic [BLKW-1:0] rd_blk = '0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_valid, ry_by;

    int checks = 0, errors = 0;
    logic m6 = 0, m2 = 0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];
    bit finished = 0;

    always #10 clk = ~clk;

    op_status_flags #(.NBLK(NBLK), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .op_busy(op_busy), .op_suspended(op_suspended), .op_timeout(op_timeout),
        .erase_hold(erase_hold), .prog_msb(prog_msb), .erase_sel(erase_sel),
        .rd_stb(rd_stb), .rd_in_bank(rd_in_bank), .rd_blk(rd_blk),
        .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid), .ry_by(ry_by)
    );

    function automatic logic [DW-1:0] fw(logic b7, logic b6, logic b5, logic b3, logic b2);
        logic [DW-1:0] w = '0;
        w[7] = b7; w[6] = b6; w[5] = b5; w[3] = b3; w[2] = b2;
        return w;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expectations as reads complete
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R11 unexpected valid", 1, 0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic rd(input int blk, input logic inb, input logic [DW-1:0] arr,
                      input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_stb = 1; rd_blk = BLKW'(blk); rd_in_bank = inb; array_data = arr;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_stb = 0;
    endtask

    // flag read with model toggles
    task automatic srd(input int blk, input logic b7, input logic b5, input logic b3,
                       input logic a6, input logic a2, input string tag);
        rd(blk, 1'b1, 16'hA5A5, fw(b7, m6, b5, b3, m2), tag);
        if (a6) m6 = ~m6;
        if (a2) m2 = ~m2;
    endtask

    task automatic start(input logic er, input logic msb);
        @(negedge clk);
        op_start = 1; op_is_erase = er; prog_msb = msb; op_busy = 1;
        @(negedge clk);
        op_start = 0;
        m6 = 0; m2 = 0;
    endtask

    task automatic step(); @(negedge clk); endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        check("R1 ready after reset", ry_by, 1);
        rd(3, 1'b1, 16'h1234, 16'h1234, "R1 idle read array");

        // program, msb = 1
        start(1'b0, 1'b1);
        check("R9 busy during program", ry_by, 0);
        srd(0, 0, 0, 0, 1, 0, "R2 program poll complement");
        srd(5, 0, 0, 0, 1, 0, "R4 toggle second read");
        srd(5, 0, 0, 0, 1, 0, "R5 bit2 steady in program");
        rd(5, 1'b0, 16'h00C3, 16'h00C3, "R10 other bank array data");
        srd(5, 0, 0, 0, 1, 0, "R10 no toggle from other bank");
        op_busy = 0; step(); step();
        check("R9 ready after done", ry_by, 1);
        rd(5, 1'b1, 16'h0080, 16'h0080, "R9 true data after program");

        // program, msb = 0, toggle reset
        start(1'b0, 1'b0);
        srd(1, 1, 0, 0, 1, 0, "R2 complement of zero, R4 first read 0");
        srd(1, 1, 0, 0, 1, 0, "R4 toggle");
        op_busy = 0; step(); step();

        // erase with hold window
        erase_sel = 16'h0005; erase_hold = 1;
        start(1'b1, 1'b0);
        srd(0, 0, 0, 0, 1, 1, "R3 erase poll 0, R8 hold window");
        srd(1, 0, 0, 0, 1, 0, "R5 unselected block steady");
        srd(2, 0, 0, 0, 1, 1, "R5 selected block toggles");
        erase_hold = 0; step(); step();
        srd(0, 0, 0, 1, 1, 1, "R8 erase proper bit3");
        op_suspended = 1; step(); step();
        check("R7 ready in suspend", ry_by, 1);
        srd(0, 1, 0, 1, 0, 1, "R7 suspend selected read");
        srd(2, 1, 0, 1, 0, 1, "R7 bit6 steady bit2 toggles");
        rd(1, 1'b1, 16'h7E7E, 16'h7E7E, "R7 unselected array data");
        op_suspended = 0; step(); step();
        check("R7 busy after resume", ry_by, 0);
        srd(0, 0, 0, 1, 1, 1, "R7 toggle resumes");
        srd(0, 0, 0, 1, 1, 1, "R4 toggle after resume");
        op_timeout = 1; step(); step();
        srd(0, 0, 1, 1, 1, 1, "R6 timeout bit5");
        srd(1, 0, 1, 1, 1, 0, "R6 toggle continues");
        check("R6 busy while failed", ry_by, 0);
        op_busy = 0; op_timeout = 0; step(); step();
        rd(0, 1'b1, 16'hFFFF, 16'hFFFF, "R3 erased word after done");

        // program timeout keeps poll value
        start(1'b0, 1'b1);
        op_timeout = 1; step(); step();
        srd(0, 0, 1, 0, 1, 0, "R6 program timeout poll kept");
        op_busy = 0; op_timeout = 0; step(); step();

        repeat (3) step();
        check("R11 all reads returned", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule